// File: doc/BRIEF.md
# Guarded Configuration Start Controller

This block launches a reconfiguration of the programmable devices downstream. A global configure level arrives from a control register. It must fall and then stay low for longer than a qualification window before anything happens. It must also fall while the configure mode is selected and the transmit mode is not. When a start is accepted, the block pulls an active-low program line low for a fixed number of time-base ticks. It then runs a configuration clock for a fixed interval. A busy flag covers the whole sequence, and an activity indicator is lit while the configuration clock runs.

All timing is counted in ticks of a time-base strobe, `tick_i`. The qualification window, the program pulse length, the clock divide ratio and the run length are all parameters. With the default 5 MHz tick they give a window longer than 2 µs, a program pulse longer than 300 ns, and a run of about 195 ms.

The per-rack configure input and the two source-select inputs are accepted but ignored. Only the local, primary source is used.

Top module: `cfg_start_ctrl`

## Requirements
- R1: During and right after reset, `prog_no_o` is 1 and `cfg_clk_o`, `led_o` and `busy_o` are 0.
- R2: A start needs `glob_cfg_i` low through more than QUAL_TICKS ticks in a row. A low span covering QUAL_TICKS or fewer ticks starts nothing. A span interrupted by a high level also starts nothing, even if its two halves add up to enough ticks.
- R3: A start is accepted only in a cycle where `enb_cfg_i` is 1 and `enb_xmit_i` is 0. If a qualified low is already present when the modes become valid, the start is taken on the next clock edge.
- R4: `rack_cfg_i`, `src_mtg_i` and `rom_alt_i` have no effect, whether the block is idle or busy.
- R5: After a start, `prog_no_o` is 0 for exactly PROG_TICKS ticks. This phase begins on the clock edge after the start condition.
- R6: After the program phase, `cfg_clk_o` gives one-cycle pulses, one every CCLK_DIV ticks, coinciding with a tick. That is RUN_TICKS/CCLK_DIV pulses per start.
- R7: `led_o` is 1 exactly during the clock-run phase, which lasts RUN_TICKS ticks.
- R8: `busy_o` is 1 from the first program cycle through the last run cycle, and is 0 otherwise.
- R9: While busy, no new start is taken. After a start, `glob_cfg_i` must be seen high while idle before another start can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| glob_cfg_i | input | 1 | Global configure level from the control register |
| rack_cfg_i | input | 1 | Per-rack configure level, ignored |
| enb_cfg_i | input | 1 | Configure mode enable |
| enb_xmit_i | input | 1 | Transmit mode enable; blocks starts |
| src_mtg_i | input | 1 | Remote source select, ignored |
| rom_alt_i | input | 1 | Alternate ROM select, ignored |
| prog_no_o | output | 1 | Active-low program output |
| cfg_clk_o | output | 1 | Configuration clock enable pulse |
| led_o | output | 1 | Activity indicator |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench drives low spans that end one tick short of the window, and a span split by a single high level. A qualifier that counted edges, or that summed split spans, would start on these.

It holds a qualified low while the modes are wrong and then repairs the modes in a single cycle. A design that latched the request too early, or forgot it, would start at the wrong time or not at all.

It keeps the configure level low after a sequence, and it lifts and drops the level again during the run phase. A design that re-armed without seeing the level high while idle would launch a second sequence. A scoreboard checks the measured program, pulse and indicator durations of every sequence, so a counter off by one shows up there.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROG = 2'd1,
    ST_RUN  = 2'd2
  } cfgs_state_e;
endpackage

// File: rtl/cfgs_qual.sv
module cfgs_qual #(
  parameter int unsigned QUAL_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic glob_cfg_i,
  input  logic idle_i,
  input  logic launch_i,
  output logic qual_o
);
  localparam int unsigned LW = $clog2(QUAL_TICKS + 2);
  localparam logic [LW-1:0] LO_SAT = LW'(QUAL_TICKS + 1);

  logic [LW-1:0] lo_cnt;
  logic          armed;

  // saturating count of ticks seen while the level stays low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
    end else if (glob_cfg_i) begin
      lo_cnt <= '0;
    end else if (tick_i && lo_cnt != LO_SAT) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // re-arm only on a high level observed while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
    end else if (launch_i) begin
      armed <= 1'b0;
    end else if (glob_cfg_i && idle_i) begin
      armed <= 1'b1;
    end
  end

  assign qual_o = armed && !glob_cfg_i && (lo_cnt == LO_SAT);
endmodule

// File: rtl/cfgs_div.sv
module cfgs_div #(
  parameter int unsigned CCLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int unsigned DW = (CCLK_DIV > 1) ? $clog2(CCLK_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(CCLK_DIV - 1);

  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
    end else if (!run_i) begin
      div_cnt <= '0;
    end else if (tick_i) begin
      div_cnt <= (div_cnt == DLAST) ? '0 : div_cnt + 1'b1;
    end
  end

  assign pulse_o = run_i && tick_i && (div_cnt == DLAST);
endmodule

// File: rtl/cfgs_seq.sv
module cfgs_seq
  import cfgs_pkg::*;
#(
  parameter int unsigned PROG_TICKS = 2,
  parameter int unsigned RUN_TICKS  = 975000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_i,
  output cfgs_state_e state_o
);
  localparam int unsigned MAXT = (PROG_TICKS > RUN_TICKS) ? PROG_TICKS : RUN_TICKS;
  localparam int unsigned TW = $clog2(MAXT + 1);
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_TICKS - 1);
  localparam logic [TW-1:0] RUN_LAST  = TW'(RUN_TICKS - 1);

  cfgs_state_e   state;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      tcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_PROG;
            tcnt  <= '0;
          end
        end
        ST_PROG: begin
          if (tick_i) begin
            if (tcnt == PROG_LAST) begin
              state <= ST_RUN;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (tcnt == RUN_LAST) begin
              state <= ST_IDLE;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          tcnt  <= '0;
        end
      endcase
    end
  end

  assign state_o = state;
endmodule

// File: rtl/cfg_start_ctrl.sv
module cfg_start_ctrl
  import cfgs_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 10,
  parameter int unsigned PROG_TICKS = 2,
  parameter int unsigned CCLK_DIV   = 4,
  parameter int unsigned RUN_TICKS  = 975000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic glob_cfg_i,
  input  logic rack_cfg_i,
  input  logic enb_cfg_i,
  input  logic enb_xmit_i,
  input  logic src_mtg_i,
  input  logic rom_alt_i,
  output logic prog_no_o,
  output logic cfg_clk_o,
  output logic led_o,
  output logic busy_o
);
  cfgs_state_e state;
  logic        qual;
  logic        idle;
  logic        start;
  logic        unused_sel;

  // source selects and rack level are deliberately dropped
  assign unused_sel = rack_cfg_i ^ src_mtg_i ^ rom_alt_i;

  assign idle  = (state == ST_IDLE);
  assign start = idle && qual && enb_cfg_i && !enb_xmit_i;

  cfgs_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .glob_cfg_i(glob_cfg_i),
    .idle_i    (idle),
    .launch_i  (start),
    .qual_o    (qual)
  );

  cfgs_seq #(.PROG_TICKS(PROG_TICKS), .RUN_TICKS(RUN_TICKS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tick_i (tick_i),
    .state_o(state)
  );

  cfgs_div #(.CCLK_DIV(CCLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_RUN),
    .tick_i (tick_i),
    .pulse_o(cfg_clk_o)
  );

  assign prog_no_o = (state != ST_PROG);
  assign led_o     = (state == ST_RUN);
  assign busy_o    = !idle;
endmodule

// File: rtl/cfg_start_ctrl_chk.sv
module cfg_start_ctrl_chk #(
  parameter int unsigned QUAL_TICKS = 10,
  parameter int unsigned PROG_TICKS = 2,
  parameter int unsigned RUN_TICKS  = 975000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic glob_cfg_i,
  input logic enb_cfg_i,
  input logic enb_xmit_i,
  input logic prog_no_o,
  input logic cfg_clk_o,
  input logic led_o,
  input logic busy_o
);
  int unsigned lo_seen;
  int unsigned prog_seen;
  int unsigned led_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_seen   <= 0;
      prog_seen <= 0;
      led_seen  <= 0;
    end else begin
      if (glob_cfg_i) lo_seen <= 0;
      else if (tick_i && lo_seen <= QUAL_TICKS) lo_seen <= lo_seen + 1;
      if (prog_no_o) prog_seen <= 0;
      else if (tick_i) prog_seen <= prog_seen + 1;
      if (!led_o) led_seen <= 0;
      else if (tick_i) led_seen <= led_seen + 1;
    end
  end

  a_r2_start_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(lo_seen > QUAL_TICKS));

  a_r3_start_mode_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enb_cfg_i && !enb_xmit_i && !glob_cfg_i));

  a_r5_prog_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_no_o) |-> (prog_seen == PROG_TICKS));

  a_r6_clk_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clk_o |-> (led_o && tick_i));

  a_r7_led_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(led_o) |-> (led_seen == RUN_TICKS));

  a_r8_busy_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_no_o || led_o) |-> busy_o);

  a_r8_starts_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !prog_no_o);

  a_r7_led_not_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> prog_no_o);
endmodule

bind cfg_start_ctrl cfg_start_ctrl_chk #(
  .QUAL_TICKS(QUAL_TICKS),
  .PROG_TICKS(PROG_TICKS),
  .RUN_TICKS (RUN_TICKS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .glob_cfg_i(glob_cfg_i),
  .enb_cfg_i (enb_cfg_i),
  .enb_xmit_i(enb_xmit_i),
  .prog_no_o (prog_no_o),
  .cfg_clk_o (cfg_clk_o),
  .led_o     (led_o),
  .busy_o    (busy_o)
);

// File: tb/tb_cfg_start_ctrl.sv
module tb_cfg_start_ctrl;
  localparam int QT = 3;
  localparam int PT = 2;
  localparam int CD = 2;
  localparam int RT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic glob_cfg_i = 1'b1;
  logic rack_cfg_i = 1'b0;
  logic enb_cfg_i = 1'b1;
  logic enb_xmit_i = 1'b0;
  logic src_mtg_i = 1'b0;
  logic rom_alt_i = 1'b0;
  logic prog_no_o, cfg_clk_o, led_o, busy_o;

  cfg_start_ctrl #(.QUAL_TICKS(QT), .PROG_TICKS(PT), .CCLK_DIV(CD), .RUN_TICKS(RT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .glob_cfg_i(glob_cfg_i),
    .rack_cfg_i(rack_cfg_i), .enb_cfg_i(enb_cfg_i), .enb_xmit_i(enb_xmit_i),
    .src_mtg_i(src_mtg_i), .rom_alt_i(rom_alt_i), .prog_no_o(prog_no_o),
    .cfg_clk_o(cfg_clk_o), .led_o(led_o), .busy_o(busy_o));

  int n_run = 0;
  int n_fail = 0;

  typedef struct {int prog; int pulses; int led;} ep_t;
  ep_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   <= (tdiv == 2) ? 0 : tdiv + 1;
    tick_i <= (tdiv == 2);
  end

  task automatic wait_ticks(input int n);
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk); #3;
      if (tick_i) cnt++;
    end
  endtask

  task automatic wait_busy(input logic val, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); #3;
      if (busy_o == val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_idle(input int n, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #3;
      if (busy_o) bad = 1'b1;
    end
    chk(!bad, req, int'(bad), 0);
  endtask

  task automatic push_exp();
    ep_t e;
    e.prog = PT; e.pulses = RT / CD; e.led = RT;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: measures each busy episode
  logic mon_busy_q = 1'b0;
  int cprog, cpulse, cled;
  always begin
    @(negedge clk); #3;
    if (rst_ni) begin
      if (busy_o && !mon_busy_q) begin cprog = 0; cpulse = 0; cled = 0; end
      if (busy_o) begin
        if (!prog_no_o && tick_i) cprog++;
        if (cfg_clk_o) cpulse++;
        if (led_o && tick_i) cled++;
      end
      if (!busy_o && mon_busy_q) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected sequence", 1, 0);
        end else begin
          ep_t e;
          e = exp_q.pop_front();
          chk(cprog == e.prog, "R5 program low ticks", cprog, e.prog);
          chk(cpulse == e.pulses, "R6 clock pulses", cpulse, e.pulses);
          chk(cled == e.led, "R7 indicator ticks", cled, e.led);
        end
      end
      mon_busy_q = busy_o;
    end
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    #3;
    chk(prog_no_o == 1'b1, "R1 prog_no in reset", prog_no_o, 1);
    chk(cfg_clk_o == 1'b0, "R1 cfg_clk in reset", cfg_clk_o, 0);
    chk(led_o == 1'b0, "R1 led in reset", led_o, 0);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R2 short low span
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT);
    @(negedge clk) glob_cfg_i = 1'b1;
    check_idle(20, "R2 short low ignored");

    // R2 split low span
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT);
    @(negedge clk) glob_cfg_i = 1'b1;
    wait_ticks(1);
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT);
    @(negedge clk) glob_cfg_i = 1'b1;
    check_idle(20, "R2 split low ignored");

    // qualified start, toggling ignored inputs while busy
    push_exp();
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT + 1);
    wait_busy(1'b1, 4, ok);
    chk(ok, "R2 qualified low starts", int'(ok), 1);
    chk(prog_no_o == 1'b0, "R8 busy begins with program", prog_no_o, 0);
    for (int i = 0; i < 200 && busy_o; i++) begin
      @(negedge clk);
      rack_cfg_i = ~rack_cfg_i; src_mtg_i = ~src_mtg_i; rom_alt_i = ~rom_alt_i;
      #3;
    end
    chk(busy_o == 1'b0, "R8 busy ends", busy_o, 0);
    check_idle(30, "R9 no restart while level held low");
    @(negedge clk) glob_cfg_i = 1'b1;
    rack_cfg_i = 1'b0; src_mtg_i = 1'b0; rom_alt_i = 1'b0;
    repeat (5) @(negedge clk);

    // R3 mode interlock
    @(negedge clk) begin enb_cfg_i = 1'b0; glob_cfg_i = 1'b0; end
    wait_ticks(QT + 2);
    check_idle(6, "R3 configure mode off blocks");
    @(negedge clk) begin enb_cfg_i = 1'b1; enb_xmit_i = 1'b1; end
    check_idle(9, "R3 transmit mode blocks");
    push_exp();
    @(negedge clk) enb_xmit_i = 1'b0;
    @(negedge clk); #3;
    chk(busy_o == 1'b1, "R3 start when modes become valid", busy_o, 1);
    wait_busy(1'b0, 200, ok);
    @(negedge clk) glob_cfg_i = 1'b1;
    repeat (5) @(negedge clk);

    // R4 ignored inputs while idle
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        rack_cfg_i = ~rack_cfg_i; src_mtg_i = i[1]; rom_alt_i = i[2];
        #3;
        if (busy_o) bad = 1'b1;
      end
      chk(!bad, "R4 rack and source inputs ignored", int'(bad), 0);
    end
    @(negedge clk) begin rack_cfg_i = 1'b0; src_mtg_i = 1'b0; rom_alt_i = 1'b0; end

    // R9 high seen only while busy does not re-arm
    push_exp();
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT + 1);
    wait_busy(1'b1, 4, ok);
    chk(ok, "R9 second start accepted", int'(ok), 1);
    while (!led_o) begin @(negedge clk); #3; end
    @(negedge clk) glob_cfg_i = 1'b1;
    wait_ticks(1);
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_busy(1'b0, 200, ok);
    check_idle(30, "R9 no re-arm from high while busy");
    @(negedge clk) glob_cfg_i = 1'b1;
    repeat (5) @(negedge clk);

    // R9 re-arm after idle high
    push_exp();
    @(negedge clk) glob_cfg_i = 1'b0;
    wait_ticks(QT + 1);
    wait_busy(1'b1, 4, ok);
    chk(ok, "R9 start after re-arm", int'(ok), 1);
    wait_busy(1'b0, 200, ok);
    @(negedge clk) glob_cfg_i = 1'b1;
    repeat (5) @(negedge clk);

    chk(exp_q.size() == 0, "R8 every expected sequence seen", exp_q.size(), 0);
    summary();
  end
endmodule